// File: doc/BRIEF.md
# MD5 Block Compression Engine

This engine runs the MD5 compression function on one 512-bit message block at a time and folds the result into a 128-bit chaining state. A front end supplies each block already padded and assembled. The block arrives as sixteen 32-bit words on one wide bus, together with a start strobe and two per-block flags. The `first` flag restarts the chaining state from the standard initial values. The `last` flag asks the engine to present the finished digest when the block is done.

A block takes a fixed 66 clock cycles:

- one cycle copies the chaining state into the working registers;
- 64 cycles run one MD5 step each;
- one cycle adds the working registers back into the chaining state.

A digest is offered on a valid/ready output and is held there until the consumer takes it. While a digest is pending, or while a block is in flight, the engine refuses new blocks.

Top module: `md5_engine`

## Requirements
- R1: After reset, `busy_o` and `digest_valid_o` are both 0.
- R2: The compression follows MD5 exactly: the four per-round logic functions, the 64 sine-derived additive constants, the per-step left-rotate amounts and the per-round message word order. The padded empty message yields d41d8cd98f00b204e9800998ecf8427e. The padded "abc" yields 900150983cd24fb0d6963f7d28e17f72.
- R3: A start is accepted on a rising edge where `start_i`=1, `busy_o`=0 and `digest_valid_o`=0. From that edge `busy_o` is 1 for exactly 66 cycles. The updated chaining state, and for a last block `digest_valid_o`, appear 66 edges after acceptance.
- R4: With `first_i`=1 at acceptance, the chaining state restarts from 67452301, efcdab89, 98badcfe, 10325476 (A..D). With `first_i`=0, the block continues from the state left by the previous block.
- R5: While `digest_valid_o`=1 and `digest_ready_i`=0, `digest_valid_o` stays 1 and `digest_o` stays stable. A rising edge with both high retires the digest.
- R6: A start while `busy_o`=1 is ignored. Neither its block nor its flags affect the result.
- R7: A start while a digest is pending (`digest_valid_o`=1) is ignored. `busy_o` stays 0.
- R8: A block accepted with `last_i`=0 does not raise `digest_valid_o`.
- R9: The digest is output as A,B,C,D. Each word is byte-swapped so that `digest_o[127:120]` is the low byte of A, which gives the standard MD5 hex string read left to right. Message word j is `block_i[32*j+31:32*j]`.
- R10: `block_i` is captured at acceptance. Later changes to it during processing have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to process the block on `block_i` |
| first_i | input | 1 | Restart the chaining state from the initial constants |
| last_i | input | 1 | Emit a digest after this block |
| block_i | input | 512 | Sixteen padded message words, word j at bits 32j+31:32j |
| busy_o | output | 1 | Block in flight |
| digest_valid_o | output | 1 | Digest available |
| digest_ready_i | input | 1 | Consumer takes the digest |
| digest_o | output | 128 | MD5 digest, standard byte order |

## Verification
The in-RTL assertions check on every cycle:

- the 66-cycle span from acceptance to the final addition;
- that a held digest stays stable while ready is low;
- that a digest is raised only by the final addition of a last block;
- that the captured block cannot change while busy;
- that no start is taken while busy or pending.

Only the bench's scenarios can show that the hash values are right. These include the standard vectors and random multi-block messages checked against an independent model that derives its constants from the sine function. The scenarios also show that the ignored starts and the block changes made mid-run leave the digest untouched.

// File: rtl/md5_pkg.sv
package md5_pkg;
  localparam int W     = 32;
  localparam int STEPS = 64;
  localparam int NWORD = 16;
  localparam int BLK_W = W * NWORD;
  localparam int IDX_W = $clog2(STEPS);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_STEP, S_FINAL} eng_state_t;

  localparam logic [31:0] K_TAB [STEPS] = '{
    32'hd76aa478, 32'he8c7b756, 32'h242070db, 32'hc1bdceee, 32'hf57c0faf, 32'h4787c62a, 32'ha8304613, 32'hfd469501,
    32'h698098d8, 32'h8b44f7af, 32'hffff5bb1, 32'h895cd7be, 32'h6b901122, 32'hfd987193, 32'ha679438e, 32'h49b40821,
    32'hf61e2562, 32'hc040b340, 32'h265e5a51, 32'he9b6c7aa, 32'hd62f105d, 32'h02441453, 32'hd8a1e681, 32'he7d3fbc8,
    32'h21e1cde6, 32'hc33707d6, 32'hf4d50d87, 32'h455a14ed, 32'ha9e3e905, 32'hfcefa3f8, 32'h676f02d9, 32'h8d2a4c8a,
    32'hfffa3942, 32'h8771f681, 32'h6d9d6122, 32'hfde5380c, 32'ha4beea44, 32'h4bdecfa9, 32'hf6bb4b60, 32'hbebfbc70,
    32'h289b7ec6, 32'heaa127fa, 32'hd4ef3085, 32'h04881d05, 32'hd9d4d039, 32'he6db99e5, 32'h1fa27cf8, 32'hc4ac5665,
    32'hf4292244, 32'h432aff97, 32'hab9423a7, 32'hfc93a039, 32'h655b59c3, 32'h8f0ccc92, 32'hffeff47d, 32'h85845dd1,
    32'h6fa87e4f, 32'hfe2ce6e0, 32'ha3014314, 32'h4e0811a1, 32'hf7537e82, 32'hbd3af235, 32'h2ad7d2bb, 32'heb86d391
  };

  // per-round nonlinear mixing function
  function automatic logic [W-1:0] md5_mix(input logic [1:0] rnd,
                                           input logic [W-1:0] b, c, d);
    case (rnd)
      2'd0:    return (b & c) | (~b & d);
      2'd1:    return (b & d) | (c & ~d);
      2'd2:    return b ^ c ^ d;
      default: return c ^ (b | ~d);
    endcase
  endfunction

  // rotate amount: depends on round and step position within a group of four
  function automatic logic [4:0] md5_rot(input logic [IDX_W-1:0] idx);
    logic [1:0] p;
    p = idx[1:0];
    case (idx[5:4])
      2'd0:    return (p == 0) ? 5'd7 : (p == 1) ? 5'd12 : (p == 2) ? 5'd17 : 5'd22;
      2'd1:    return (p == 0) ? 5'd5 : (p == 1) ? 5'd9  : (p == 2) ? 5'd14 : 5'd20;
      2'd2:    return (p == 0) ? 5'd4 : (p == 1) ? 5'd11 : (p == 2) ? 5'd16 : 5'd23;
      default: return (p == 0) ? 5'd6 : (p == 1) ? 5'd10 : (p == 2) ? 5'd15 : 5'd21;
    endcase
  endfunction

  // message word selector per round
  function automatic logic [3:0] md5_widx(input logic [IDX_W-1:0] idx);
    logic [3:0] i4;
    i4 = idx[3:0];
    case (idx[5:4])
      2'd0:    return i4;
      2'd1:    return 4'((i4 << 2) + i4 + 4'd1);
      2'd2:    return 4'((i4 << 1) + i4 + 4'd5);
      default: return 4'((i4 << 3) - i4);
    endcase
  endfunction

  function automatic logic [W-1:0] rotl32(input logic [W-1:0] x, input logic [4:0] s);
    logic [2*W-1:0] t;
    t = {x, x} << s;
    return t[2*W-1:W];
  endfunction

  function automatic logic [W-1:0] bswap32(input logic [W-1:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction
endpackage

// File: rtl/md5_step_unit.sv
module md5_step_unit
  import md5_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [W-1:0]     c_i,
  input  logic [W-1:0]     d_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic [W-1:0]     a_o,
  output logic [W-1:0]     b_o,
  output logic [W-1:0]     c_o,
  output logic [W-1:0]     d_o
);
  logic [W-1:0] msg [NWORD];
  for (genvar j = 0; j < NWORD; j++) begin : g_words
    assign msg[j] = blk_i[W*j +: W];
  end

  logic [W-1:0] sum_w;
  always_comb begin
    sum_w = a_i + md5_mix(idx_i[5:4], b_i, c_i, d_i) + K_TAB[idx_i] + msg[md5_widx(idx_i)];
    a_o   = d_i;
    b_o   = b_i + rotl32(sum_w, md5_rot(idx_i));
    c_o   = b_i;
    d_o   = c_i;
  end
endmodule

// File: rtl/md5_seq_ctrl.sv
module md5_seq_ctrl
  import md5_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             hold_i,
  output logic             accept_o,
  output logic             load_o,
  output logic             step_o,
  output logic             final_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o
);
  eng_state_t st_q;
  logic [IDX_W-1:0] idx_q;

  assign accept_o = (st_q == S_IDLE) && start_i && !hold_i;
  assign load_o   = (st_q == S_LOAD);
  assign step_o   = (st_q == S_STEP);
  assign final_o  = (st_q == S_FINAL);
  assign busy_o   = (st_q != S_IDLE);
  assign idx_o    = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
    end else begin
      case (st_q)
        S_IDLE:  if (accept_o) st_q <= S_LOAD;
        S_LOAD:  begin st_q <= S_STEP; idx_q <= '0; end
        S_STEP:  begin
          if (idx_q == IDX_W'(STEPS - 1)) st_q <= S_FINAL;
          idx_q <= idx_q + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // the step phase must end exactly after the last step index
  AST_STEP_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    final_o |-> $past(step_o) && ($past(idx_q) == IDX_W'(STEPS - 1))); // R3
endmodule

// File: rtl/md5_engine.sv
module md5_engine
  import md5_pkg::*;
#(
  parameter logic [31:0] IV_A = 32'h67452301,
  parameter logic [31:0] IV_B = 32'hefcdab89,
  parameter logic [31:0] IV_C = 32'h98badcfe,
  parameter logic [31:0] IV_D = 32'h10325476
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           first_i,
  input  logic           last_i,
  input  logic [511:0]   block_i,
  output logic           busy_o,
  output logic           digest_valid_o,
  input  logic           digest_ready_i,
  output logic [127:0]   digest_o
);
  localparam int LAT = STEPS + 2;

  logic             accept_w, load_w, step_w, final_w;
  logic [IDX_W-1:0] idx_w;
  logic [BLK_W-1:0] blk_q;
  logic             last_q, dvalid_q;
  logic [W-1:0]     chain_q [4];
  logic [W-1:0]     work_q  [4];
  logic [W-1:0]     next_w  [4];

  md5_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hold_i(dvalid_q),
    .accept_o(accept_w), .load_o(load_w), .step_o(step_w), .final_o(final_w),
    .idx_o(idx_w), .busy_o(busy_o)
  );

  md5_step_unit u_step (
    .idx_i(idx_w), .a_i(work_q[0]), .b_i(work_q[1]), .c_i(work_q[2]), .d_i(work_q[3]),
    .blk_i(blk_q), .a_o(next_w[0]), .b_o(next_w[1]), .c_o(next_w[2]), .d_o(next_w[3])
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q    <= '0;
      last_q   <= 1'b0;
      dvalid_q <= 1'b0;
      chain_q  <= '{IV_A, IV_B, IV_C, IV_D};
      work_q   <= '{default: '0};
    end else begin
      if (accept_w) begin
        blk_q  <= block_i;
        last_q <= last_i;
        if (first_i) chain_q <= '{IV_A, IV_B, IV_C, IV_D};
      end
      if (load_w) work_q <= chain_q;
      if (step_w) work_q <= next_w;
      if (final_w) begin
        for (int k = 0; k < 4; k++) chain_q[k] <= chain_q[k] + work_q[k];
        if (last_q) dvalid_q <= 1'b1;
      end else if (dvalid_q && digest_ready_i) begin
        dvalid_q <= 1'b0;
      end
    end
  end

  assign digest_valid_o = dvalid_q;
  for (genvar k = 0; k < 4; k++) begin : g_out
    assign digest_o[127 - 32*k -: 32] = bswap32(chain_q[k]);
  end

  // checker-only cycle counter from acceptance
  logic [6:0] chk_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           chk_cnt <= '0;
    else if (accept_w)    chk_cnt <= 7'd1;
    else if (busy_o)      chk_cnt <= chk_cnt + 1'b1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    final_w |-> chk_cnt == 7'(LAT)); // R3
  AST_DIGEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (digest_valid_o && !digest_ready_i) |=> digest_valid_o && $stable(digest_o)); // R5
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |-> !busy_o && !digest_valid_o); // R6
  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(digest_valid_o) |-> $past(final_w) && $past(last_q)); // R8
  AST_BLOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(blk_q)); // R10
endmodule

// File: tb/sim_md5_engine.sv
module sim_md5_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0, first_i = 1'b0, last_i = 1'b0;
  logic [511:0] block_i = '0;
  logic         digest_ready_i = 1'b0;
  logic         busy_o, digest_valid_o;
  logic [127:0] digest_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] mk [64];
  logic [31:0] mchain [4];

  md5_engine u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .first_i(first_i), .last_i(last_i),
    .block_i(block_i), .busy_o(busy_o), .digest_valid_o(digest_valid_o),
    .digest_ready_i(digest_ready_i), .digest_o(digest_o)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input int s);
    return (x << s) | (x >> (32 - s));
  endfunction

  // independent model of one compression
  function automatic void model_block(input logic [511:0] blk, input bit first);
    int sh [16] = '{7,12,17,22, 5,9,14,20, 4,11,16,23, 6,10,15,21};
    logic [31:0] a, b, c, d, f, t;
    int g;
    if (first) mchain = '{32'h67452301, 32'hefcdab89, 32'h98badcfe, 32'h10325476};
    a = mchain[0]; b = mchain[1]; c = mchain[2]; d = mchain[3];
    for (int i = 0; i < 64; i++) begin
      if (i < 16)      begin f = d ^ (b & (c ^ d)); g = i; end
      else if (i < 32) begin f = c ^ (d & (b ^ c)); g = (1 + 5 * (i - 16)) % 16; end
      else if (i < 48) begin f = b ^ c ^ d;         g = (5 + 3 * (i - 32)) % 16; end
      else             begin f = c ^ (b | ~d);      g = (7 * (i - 48)) % 16; end
      t = a + f + mk[i] + blk[32*g +: 32];
      a = d; d = c; c = b;
      b = b + rl(t, sh[(i / 16) * 4 + (i % 4)]);
    end
    mchain[0] += a; mchain[1] += b; mchain[2] += c; mchain[3] += d;
  endfunction

  function automatic logic [127:0] model_digest();
    logic [127:0] r;
    for (int w = 0; w < 4; w++)
      for (int by = 0; by < 4; by++)
        r[127 - 32*w - 8*by -: 8] = mchain[w][8*by +: 8];
    return r;
  endfunction

  function automatic logic [511:0] rnd_block();
    logic [511:0] r;
    for (int j = 0; j < 16; j++) r[32*j +: 32] = $urandom;
    return r;
  endfunction

  // drive one block; optional poke issues a start while busy and scrambles block_i
  task automatic run_block(input logic [511:0] blk, input bit first, input bit last, input bit poke);
    int n;
    @(negedge clk);
    block_i = blk; first_i = first; last_i = last; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) block_i = rnd_block();             // R10
    model_block(blk, first);
    n = 0;
    while (busy_o && n < 100) begin
      n++;
      if (poke && n == 30) begin start_i = 1'b1; first_i = ~first; end // R6
      else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    check(n == 66, "R3 busy length", 128'(n), 128'd66);
    if (!last) check(digest_valid_o == 1'b0, "R8 no digest for non-last block", 128'(digest_valid_o), 128'd0);
    else       check(digest_valid_o == 1'b1, "R3 digest valid after last block", 128'(digest_valid_o), 128'd1);
  endtask

  task automatic take_digest(input logic [127:0] exp, input string tag, input int stall);
    logic [127:0] held;
    check(digest_o == exp, tag, digest_o, exp);
    held = digest_o;
    repeat (stall) @(negedge clk);
    check(digest_valid_o && digest_o == held, "R5 held while stalled", digest_o, held);
    digest_ready_i = 1'b1;
    @(negedge clk);
    digest_ready_i = 1'b0;
    check(digest_valid_o == 1'b0, "R5 retired on handshake", 128'(digest_valid_o), 128'd0);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [511:0] blk;
    logic [127:0] held;
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) mk[i] = 32'(longint'($floor($sqrt(1.0) * ($sin(real'(i + 1)) < 0 ? -$sin(real'(i + 1)) : $sin(real'(i + 1))) * 4294967296.0)));

    repeat (3) @(negedge clk);
    check(busy_o == 1'b0 && digest_valid_o == 1'b0, "R1 reset state", {busy_o, digest_valid_o}, 128'd0);
    rst_n = 1'b1;

    // empty message, padded
    blk = '0; blk[31:0] = 32'h00000080;
    run_block(blk, 1'b1, 1'b1, 1'b0);
    take_digest(128'hd41d8cd98f00b204e9800998ecf8427e, "R2 empty message vector", 0);
    check(model_digest() == 128'hd41d8cd98f00b204e9800998ecf8427e, "R9 model byte order", model_digest(), 128'hd41d8cd98f00b204e9800998ecf8427e);

    // "abc" with start-while-busy and block scramble
    blk = '0; blk[31:0] = 32'h80636261; blk[14*32 +: 32] = 32'd24;
    run_block(blk, 1'b1, 1'b1, 1'b1);
    take_digest(128'h900150983cd24fb0d6963f7d28e17f72, "R2 R6 R10 abc vector", 5);

    // two-block chained message, then R7: start while digest pending
    run_block(rnd_block(), 1'b1, 1'b0, 1'b0);
    run_block(rnd_block(), 1'b0, 1'b1, 1'b0);
    held = digest_o;
    @(negedge clk);
    start_i = 1'b1; first_i = 1'b1; last_i = 1'b1; block_i = rnd_block();
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b0, "R7 start ignored while pending", 128'(busy_o), 128'd0);
    check(digest_o == held, "R7 digest untouched", digest_o, held);
    take_digest(model_digest(), "R4 chained two-block digest", 3);

    // first=0 after a completed message continues from its chain
    run_block(rnd_block(), 1'b0, 1'b1, 1'b0);
    take_digest(model_digest(), "R4 continue without first", 1);

    // random messages of 1..3 blocks
    for (int m = 0; m < 20; m++) begin
      int nb;
      nb = 1 + int'($urandom % 3);
      for (int b = 0; b < nb; b++)
        run_block(rnd_block(), b == 0, b == nb - 1, ($urandom % 4) == 0);
      take_digest(model_digest(), "R2 random message", int'($urandom % 6));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule